// File: doc/BRIEF.md
# Interrupt Request Collector for a Small Microcontroller Core

This block gathers every interrupt source of a small 8-bit microcontroller core and turns them into two requests. The first, `cpu_irq`, tells the core to take an interrupt. The second, `wake_req`, tells the sleep controller to resume clocking.

Three core sources are handled inside the block:
- an external pin, with a software-chosen active edge;
- a timer overflow pulse;
- a change detector on a four-bit slice of an input port.

A bank of peripheral sources also feeds the block. Each peripheral has a pending bit and a per-source enable. The OR of those enabled terms passes through one peripheral-group enable before it joins the core sources. All pending bits are sticky: they stay set until software writes them back to 0.

Software reaches the state through a small register bus with four 8-bit locations:
- the control register, holding the core flags, the core enables, the group enable and the global enable;
- an option register, holding the edge-polarity bit;
- the peripheral pending register;
- the peripheral enable register.

Reads are combinational. A write takes effect at the clock edge on which `reg_wr` is sampled high.

Top module: `irq_collector`

## Requirements
- R1: After reset all four registers read 0, and `cpu_irq` and `wake_req` are 0.
- R2: Address 1, bit 6 selects the external pin's active edge: 1 = rising, 0 = falling. Only the active edge sets control bit 1; the other edge leaves it unchanged. All other bits of address 1 read 0.
- R3: A one-cycle high on `tmr_ovf` sets control bit 2.
- R4: A change on any bit of `port_hi` sets control bit 0.
- R5: Control register (address 0) layout:
  - bits 2..0 are the timer, external and port flags;
  - bits 5..3 are the timer, external and port enables;
  - bit 6 is the peripheral-group enable;
  - bit 7 is the global enable.

  Flags stay set until a write to address 0 puts a 0 in their bit. Every bit reads back the value last written, except where an event sets a flag.
- R6: A one-cycle high on `periph_evt[i]` sets bit i of address 2. Address 3 bit i is that source's enable. Peripheral bit i requests only when its flag, its enable and control bit 6 are all 1.
- R7: `wake_req` is 1 exactly when some source is pending and enabled, with peripheral sources also needing the group enable. The global enable plays no part.
- R8: `cpu_irq` equals `wake_req` ANDed with control bit 7.
- R9: If an event for a flag arrives in the same cycle as a write that clears that flag, the flag ends up set.
- R10: Changing the polarity bit while the pin holds still sets no flag.
- R11: The pin and the port slice are each passed through two synchronizing flops. A pin change applied before clock edge 1 shows in the flag after edge 3, and not after edge 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_pin | input | 1 | External interrupt pin (asynchronous) |
| port_hi | input | PORT_W | Watched input port slice (asynchronous) |
| tmr_ovf | input | 1 | Timer wrap pulse, one cycle |
| periph_evt | input | NPERIPH | Peripheral event pulses, one cycle each |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| cpu_irq | output | 1 | Interrupt request to the core |
| wake_req | output | 1 | Wake-up request to the sleep controller |

## Verification
A hardware event and a software clear can strike the same flag in one cycle. The bench provokes this by raising `tmr_ovf` together with a control-register write that zeroes bit 2. It does the same with a peripheral pulse and a zeroing write to address 2. It then reads the register back and expects the flag still set.

A second collision is a polarity change while the pin is steady. The flag must stay clear across several cycles afterwards.

The request outputs are judged against an arithmetic model over every control-register value and every combination of peripheral flags, peripheral enables and the group enable.

// File: rtl/irq_collector_pkg.sv
package irq_collector_pkg;
    localparam int REG_W  = 8;
    localparam int ADDR_W = 2;
    localparam int NCORE  = 3;

    localparam logic [ADDR_W-1:0] ADDR_CTL  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_OPT  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_PFLG = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_PEN  = 2'd3;

    // control register bit positions
    localparam int B_PRT_F = 0;
    localparam int B_EXT_F = 1;
    localparam int B_TMR_F = 2;
    localparam int B_PRT_E = 3;
    localparam int B_EXT_E = 4;
    localparam int B_TMR_E = 5;
    localparam int B_GRP_E = 6;
    localparam int B_GLB_E = 7;
    // option register bit position
    localparam int B_POL   = 6;

    typedef struct packed {
        logic glb_en;
        logic grp_en;
        logic tmr_en;
        logic ext_en;
        logic prt_en;
        logic pol;
    } cfg_t;
endpackage

// File: rtl/irq_edge_sense.sv
module irq_edge_sense #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [W-1:0] chg
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] prev;
    } sense_t;

    sense_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = din;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl = st_q.s2;
    assign chg = st_q.s2 ^ st_q.prev;
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] flags
);
    logic [W-1:0] flags_d, flags_q;

    always_comb begin
        flags_d = flags_q;
        if (wr) flags_d = wdata;
        flags_d = flags_d | evt;   // a same-cycle event outranks the write
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags = flags_q;
endmodule

// File: rtl/irq_collector.sv
module irq_collector
    import irq_collector_pkg::*;
#(
    parameter int NPERIPH = 4,
    parameter int PORT_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ext_pin,
    input  logic [PORT_W-1:0]  port_hi,
    input  logic               tmr_ovf,
    input  logic [NPERIPH-1:0] periph_evt,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    output logic               cpu_irq,
    output logic               wake_req
);
    typedef struct packed {
        cfg_t               cfg;
        logic [NPERIPH-1:0] pen;
    } st_t;

    st_t st_d, st_q;

    logic               ext_lvl, ext_chg, ext_evt;
    logic [PORT_W-1:0]  port_lvl, port_chg;
    logic [NCORE-1:0]   core_evt, core_flags_q, core_en;
    logic [NPERIPH-1:0] pflags_q;
    logic               core_wr, pflg_wr;
    logic               core_hit, periph_hit;
    logic               glb_en_w, grp_en_w;
    logic               unused_port_lvl;

    irq_edge_sense #(.W(1)) u_ext_sense (
        .clk(clk), .rst_n(rst_n), .din(ext_pin), .lvl(ext_lvl), .chg(ext_chg)
    );

    irq_edge_sense #(.W(PORT_W)) u_port_sense (
        .clk(clk), .rst_n(rst_n), .din(port_hi), .lvl(port_lvl), .chg(port_chg)
    );

    assign unused_port_lvl = &{1'b0, port_lvl};

    // detection follows only pin history, so a polarity flip adds no edge
    assign ext_evt = ext_chg & (st_q.cfg.pol ? ext_lvl : ~ext_lvl);

    always_comb begin
        core_evt          = '0;
        core_evt[B_PRT_F] = |port_chg;
        core_evt[B_EXT_F] = ext_evt;
        core_evt[B_TMR_F] = tmr_ovf;
    end

    assign core_wr = reg_wr && (reg_addr == ADDR_CTL);
    assign pflg_wr = reg_wr && (reg_addr == ADDR_PFLG);

    irq_flag_bank #(.W(NCORE)) u_core_flags (
        .clk(clk), .rst_n(rst_n), .evt(core_evt), .wr(core_wr),
        .wdata(reg_wdata[NCORE-1:0]), .flags(core_flags_q)
    );

    irq_flag_bank #(.W(NPERIPH)) u_periph_flags (
        .clk(clk), .rst_n(rst_n), .evt(periph_evt), .wr(pflg_wr),
        .wdata(reg_wdata[NPERIPH-1:0]), .flags(pflags_q)
    );

    // configuration registers
    always_comb begin
        st_d = st_q;
        if (reg_wr) begin
            case (reg_addr)
                ADDR_CTL: begin
                    st_d.cfg.prt_en = reg_wdata[B_PRT_E];
                    st_d.cfg.ext_en = reg_wdata[B_EXT_E];
                    st_d.cfg.tmr_en = reg_wdata[B_TMR_E];
                    st_d.cfg.grp_en = reg_wdata[B_GRP_E];
                    st_d.cfg.glb_en = reg_wdata[B_GLB_E];
                end
                ADDR_OPT: st_d.cfg.pol = reg_wdata[B_POL];
                ADDR_PEN: st_d.pen     = reg_wdata[NPERIPH-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // request combining
    always_comb begin
        core_en          = '0;
        core_en[B_PRT_F] = st_q.cfg.prt_en;
        core_en[B_EXT_F] = st_q.cfg.ext_en;
        core_en[B_TMR_F] = st_q.cfg.tmr_en;
    end

    assign core_hit   = |(core_flags_q & core_en);
    assign periph_hit = st_q.cfg.grp_en & (|(pflags_q & st_q.pen));
    assign wake_req   = core_hit | periph_hit;
    assign cpu_irq    = wake_req & st_q.cfg.glb_en;

    assign glb_en_w = st_q.cfg.glb_en;
    assign grp_en_w = st_q.cfg.grp_en;

    // read mux
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTL: begin
                reg_rdata[NCORE-1:0] = core_flags_q;
                reg_rdata[B_PRT_E]   = st_q.cfg.prt_en;
                reg_rdata[B_EXT_E]   = st_q.cfg.ext_en;
                reg_rdata[B_TMR_E]   = st_q.cfg.tmr_en;
                reg_rdata[B_GRP_E]   = st_q.cfg.grp_en;
                reg_rdata[B_GLB_E]   = st_q.cfg.glb_en;
            end
            ADDR_OPT:  reg_rdata[B_POL]         = st_q.cfg.pol;
            ADDR_PFLG: reg_rdata[NPERIPH-1:0]   = pflags_q;
            default:   reg_rdata[NPERIPH-1:0]   = st_q.pen;
        endcase
    end
endmodule

// File: rtl/irq_collector_chk.sv
module irq_collector_chk
    import irq_collector_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_irq,
    input logic              wake_req,
    input logic              tmr_ovf,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [REG_W-1:0]  reg_wdata,
    input logic [NCORE-1:0]  core_flags,
    input logic              glb_en,
    input logic              grp_en
);
    // R8: no request to the core without the global enable
    a_r8_irq_needs_global: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> glb_en);

    // R7: every core request is also a wake request
    a_r7_wake_covers_irq: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> wake_req);

    // R3: an overflow pulse leaves the timer flag set
    a_r3_ovf_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_ovf |=> core_flags[B_TMR_F]);

    // R9: the event beats a clearing write in the same cycle
    a_r9_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_ovf && reg_wr && reg_addr == ADDR_CTL && !reg_wdata[B_TMR_F])
        |=> core_flags[B_TMR_F]);

    // R5: a pending external flag survives while no control write happens
    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (core_flags[B_EXT_F] && !(reg_wr && reg_addr == ADDR_CTL))
        |=> core_flags[B_EXT_F]);

    // R6: with the group enable off and no core flag, nothing wakes
    a_r6_group_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!grp_en && core_flags == '0) |-> !wake_req);
endmodule

bind irq_collector irq_collector_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_irq(cpu_irq), .wake_req(wake_req),
    .tmr_ovf(tmr_ovf), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .core_flags(core_flags_q),
    .glb_en(glb_en_w), .grp_en(grp_en_w)
);

// File: tb/irq_collector_tb.sv
module irq_collector_tb_top;
    localparam int NP = 4;
    localparam int PW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ext_pin = 1'b0;
    logic [PW-1:0] port_hi = '0;
    logic          tmr_ovf = 1'b0;
    logic [NP-1:0] periph_evt = '0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = '0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic          cpu_irq, wake_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    irq_collector #(.NPERIPH(NP), .PORT_W(PW)) dut_i (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .port_hi(port_hi),
        .tmr_ovf(tmr_ovf), .periph_evt(periph_evt), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cpu_irq(cpu_irq), .wake_req(wake_req)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic       lvl;
        logic [7:0] pacc;

        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v);
            chk("R1 reset reg", v, 8'h00);
        end
        chk("R1 reset irq", {7'd0, cpu_irq}, 8'h00);
        chk("R1 reset wake", {7'd0, wake_req}, 8'h00);

        // R2 option readback: only bit 6 holds
        wr(2'd1, 8'hFF);
        rd(2'd1, v);
        chk("R2 option bits", v, 8'h40);

        // R11 latency, rising edge with polarity 1
        @(negedge clk);
        ext_pin = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rd(2'd0, v);
        chk("R11 not after edge 2", v & 8'h02, 8'h00);
        @(negedge clk);
        rd(2'd0, v);
        chk("R11 set after edge 3", v & 8'h02, 8'h02);
        wr(2'd0, 8'h00);

        // R2 polarity sweep, two toggles per polarity
        lvl = 1'b1;
        for (int p = 0; p < 2; p++) begin
            for (int t = 0; t < 2; t++) begin
                wr(2'd1, p[0] ? 8'h40 : 8'h00);
                wr(2'd0, 8'h00);
                @(negedge clk);
                lvl = ~lvl;
                ext_pin = lvl;
                idle(4);
                rd(2'd0, v);
                chk("R2 edge select", v & 8'h02, ((p[0] ? lvl : ~lvl) ? 8'h02 : 8'h00));
            end
        end

        // R10 polarity flips with pin steady
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h00);
        idle(4);
        rd(2'd0, v);
        chk("R10 flip to falling", v & 8'h02, 8'h00);
        wr(2'd1, 8'h40);
        idle(4);
        rd(2'd0, v);
        chk("R10 flip to rising", v & 8'h02, 8'h00);

        // R5 stickiness: set external flag, wait, then clear by write
        @(negedge clk);
        lvl = ~lvl;
        ext_pin = lvl;       // polarity 1: expected edge is rising if lvl=1
        if (!lvl) begin
            idle(4);
            @(negedge clk);
            lvl = 1'b1;
            ext_pin = lvl;
        end
        idle(12);
        rd(2'd0, v);
        chk("R5 flag held", v & 8'h02, 8'h02);
        wr(2'd0, 8'h00);
        rd(2'd0, v);
        chk("R5 flag cleared by write", v & 8'h02, 8'h00);

        // R4 every port bit
        for (int i = 0; i < PW; i++) begin
            wr(2'd0, 8'h00);
            idle(4);
            rd(2'd0, v);
            chk("R4 no change no flag", v & 8'h01, 8'h00);
            @(negedge clk);
            port_hi[i] = ~port_hi[i];
            idle(4);
            rd(2'd0, v);
            chk("R4 port change flag", v & 8'h01, 8'h01);
        end
        wr(2'd0, 8'h00);

        // R3 timer with enable and global enable combinations
        for (int e = 0; e < 2; e++) begin
            for (int g = 0; g < 2; g++) begin
                wr(2'd0, {g[0], 1'b0, e[0], 5'b0});
                @(negedge clk);
                tmr_ovf = 1'b1;
                @(negedge clk);
                tmr_ovf = 1'b0;
                rd(2'd0, v);
                chk("R3 timer flag", v & 8'h04, 8'h04);
                chk("R7 timer wake", {7'd0, wake_req}, {7'd0, e[0]});
                chk("R8 timer irq", {7'd0, cpu_irq}, {7'd0, e[0] & g[0]});
            end
        end

        // R9 timer event against clearing write
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h00; tmr_ovf = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; tmr_ovf = 1'b0;
        rd(2'd0, v);
        chk("R9 timer event wins", v, 8'h04);

        // R5 R7 R8 every control value
        for (int c = 0; c < 256; c++) begin
            logic [7:0] cv;
            logic       wexp;
            cv = c[7:0];
            wr(2'd0, cv);
            rd(2'd0, v);
            chk("R5 control readback", v, cv);
            wexp = |(cv[2:0] & cv[5:3]);
            chk("R7 wake model", {7'd0, wake_req}, {7'd0, wexp});
            chk("R8 irq model", {7'd0, cpu_irq}, {7'd0, wexp & cv[7]});
        end
        wr(2'd0, 8'h00);

        // R6 event pulses set peripheral flags
        pacc = 8'h00;
        for (int i = 0; i < NP; i++) begin
            @(negedge clk);
            periph_evt = NP'(1) << i;
            @(negedge clk);
            periph_evt = '0;
            pacc[i] = 1'b1;
            rd(2'd2, v);
            chk("R6 peripheral flag set", v, pacc);
        end

        // R9 peripheral event against clearing write
        wr(2'd2, 8'h00);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 8'h00; periph_evt = NP'(1);
        @(negedge clk);
        reg_wr = 1'b0; periph_evt = '0;
        rd(2'd2, v);
        chk("R9 peripheral event wins", v, 8'h01);

        // R6 R7 R8 sweep: group enable x per-source enables x flags
        for (int ge = 0; ge < 2; ge++) begin
            for (int g = 0; g < 2; g++) begin
                wr(2'd0, {g[0], ge[0], 6'b0});
                for (int en = 0; en < 16; en++) begin
                    wr(2'd3, en[7:0]);
                    rd(2'd3, v);
                    chk("R6 enable readback", v, en[7:0]);
                    for (int f = 0; f < 16; f++) begin
                        logic wexp;
                        wr(2'd2, f[7:0]);
                        wexp = ge[0] & (|(f[3:0] & en[3:0]));
                        chk("R6 peripheral wake", {7'd0, wake_req}, {7'd0, wexp});
                        chk("R8 peripheral irq", {7'd0, cpu_irq}, {7'd0, wexp & g[0]});
                    end
                end
            end
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule